// File: doc/BRIEF.md
# Serial Controller Register Front End

This block sits between a processor bus and the transmit and receive engines of a programmable serial controller. It decodes a chip select, a control/data selector and single-cycle read and write strobes, and steers each access: data writes go to the transmit holding register and data reads come from the receive buffer. Control writes and status reads are handled here.

A control write does not always mean the same thing. After reset, the first control write is the configuration word. If that word picks synchronous operation, one or two sync-character writes follow. Only after that are control writes treated as commands. One command bit sends the block back to waiting for a configuration word. The block holds the decoded configuration fields and the level-held command bits, and drives the two active-low modem handshake outputs. It keeps sticky parity, overrun and framing flags that the receiver raises by pulses. It builds the status byte and gates the transmitter-ready pin.

Top module: `usart_regif`

## Requirements
- R1: While `rst` is high and after it, `cfg_ready`, `tx_en`, `rx_en`, `send_brk`, `hunt` and all error flags are 0, `dtr_n` and `rts_n` are 1, and the configuration and sync registers are 0.
- R2: The first control write (`cs_n`=0, `cd_sel`=1, `wr_stb`=1) after reset or internal reset is stored as the configuration word. It is decoded as follows: `baud_sel`=bits[1:0], where 00 means synchronous, 01 ×1, 10 ×16 and 11 ×64; `char_len`=bits[3:2] (5 to 8 data bits); `par_en`=bit 4; `par_even`=bit 5. A non-zero `baud_sel` sets `cfg_ready` from the next cycle.
- R3: In asynchronous operation, `stop_sel` equals configuration bits[7:6], where 00 is invalid, 01 one, 10 one and a half and 11 two stop bits. In this case `ext_sync` and `single_sync` read 0.
- R4: When bits[1:0] are 00, the sequence is synchronous. `ext_sync`=bit 6, `single_sync`=bit 7 and `stop_sel`=0. The next control write is stored in `sync1`. If `single_sync` is 0, a further control write is stored in `sync2`. `cfg_ready` rises only in the cycle after the last required sync write.
- R5: Control writes taken while `cfg_ready` is 0 never change the command outputs or the modem outputs.
- R6: A command write with bit 6 clear loads the command bits, which stay held until the next command write. The bits are: bit 0 `tx_en`, bit 2 `rx_en`, bit 3 `send_brk` and bit 7 `hunt`. `dtr_n` is the inverse of bit 1 and `rts_n` is the inverse of bit 5.
- R7: Pulses on `par_set`, `ovr_set` and `frm_set` set sticky flags. A command write with bit 4 clears all three flags at the following edge, unless a set pulse arrives in that same cycle, in which case the set wins.
- R8: A command write with bit 6 set returns the block to waiting for a configuration word. It clears all command bits and error flags, and ignores the other bits of that word. The configuration and sync fields keep their values until they are rewritten.
- R9: A status read (`cs_n`=0, `cd_sel`=1, `rd_stb`=1) returns the status byte on `dout` in the same cycle. The bits are: bit 0 `hold_empty`, bit 1 `rx_avail`, bit 2 `shift_empty`, bit 3 parity flag, bit 4 overrun flag, bit 5 framing flag, bit 6 `sync_flag`, bit 7 the inverse of `dsr_n`. Bit 0 does not depend on `cts_n` or `tx_en`.
- R10: `txrdy_pin` is 1 only when `hold_empty` is 1, `cts_n` is 0 and `tx_en` is 1.
- R11: A data write (`cs_n`=0, `cd_sel`=0, `wr_stb`=1) pulses `tx_load` in that cycle with `tx_byte` equal to `din`. A data read pulses `rx_take` and returns `rx_byte` on `dout`.
- R12: With `cs_n` high, strobes have no effect: `dout` is 0, `tx_load` and `rx_take` stay 0, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cd_sel | input | 1 | 1 selects control/status, 0 selects data |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor, 0 when not reading |
| tx_load | output | 1 | Load pulse for the transmit holding register |
| tx_byte | output | 8 | Byte for the transmit holding register |
| rx_take | output | 1 | Pulse telling the receiver its buffer was read |
| rx_byte | input | 8 | Receive buffer contents |
| hold_empty | input | 1 | Transmit holding register empty |
| shift_empty | input | 1 | Transmitter fully idle |
| rx_avail | input | 1 | Receive buffer holds a character |
| par_set | input | 1 | Parity error pulse from the receiver |
| ovr_set | input | 1 | Overrun pulse from the receiver |
| frm_set | input | 1 | Framing error pulse from the receiver |
| sync_flag | input | 1 | Sync found / break seen indication |
| dsr_n | input | 1 | Modem data-set-ready, active low |
| cts_n | input | 1 | Modem clear-to-send, active low |
| txrdy_pin | output | 1 | Gated transmitter-ready indication |
| dtr_n | output | 1 | Modem terminal-ready, active low |
| rts_n | output | 1 | Modem request-to-send, active low |
| tx_en | output | 1 | Transmit enable command bit |
| rx_en | output | 1 | Receive enable command bit |
| send_brk | output | 1 | Force break command bit |
| hunt | output | 1 | Sync search command bit |
| cfg_ready | output | 1 | Initialisation complete, commands accepted |
| baud_sel | output | 2 | Timing factor / synchronous select |
| char_len | output | 2 | Data bit count code |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| stop_sel | output | 2 | Stop bit code, 0 in synchronous operation |
| ext_sync | output | 1 | External sync detection selected |
| single_sync | output | 1 | One sync character instead of two |
| sync1 | output | 8 | First sync character |
| sync2 | output | 8 | Second sync character |

## Verification
The most likely wrong internal state is a sequencer in the wrong phase. It shows up one cycle after the write that should have moved it. The evidence is `cfg_ready` rising too early or too late, or a sync byte landing in a command output, which flips `dtr_n` or `rts_n` at once. A sticky flag that fails to clear, or clears when it should hold, shows up on the very next status read. A mis-gated ready pin shows up in the same cycle that `cts_n` or `tx_en` changes. The bench compares every output against a behavioural model on every clock, so each of these is caught in the cycle it first appears.

// File: rtl/usart_regif_pkg.sv
package usart_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int N_ERR  = 3;

    typedef enum logic [1:0] {
        ST_MODE  = 2'd0,
        ST_SYNC1 = 2'd1,
        ST_SYNC2 = 2'd2,
        ST_CMD   = 2'd3
    } cfg_state_e;

    // configuration word; field order follows bit position
    typedef struct packed {
        logic [SEL_W-1:0] hi;       // stop code (async) or sync options
        logic             par_even;
        logic             par_en;
        logic [SEL_W-1:0] char_len;
        logic [SEL_W-1:0] baud;
    } mode_t;

    // command word; field order follows bit position
    typedef struct packed {
        logic hunt;
        logic irst;
        logic rts;
        logic eclr;
        logic brk;
        logic rxe;
        logic dtr;
        logic txe;
    } cmd_t;

    // status byte; field order follows bit position
    typedef struct packed {
        logic dsr;
        logic syn;
        logic fe;
        logic oe;
        logic pe;
        logic txempty;
        logic rxrdy;
        logic txrdy;
    } status_t;

    function automatic logic is_sync(input mode_t m);
        return m.baud == '0;
    endfunction

endpackage

// File: rtl/usart_regif_seq.sv
module usart_regif_seq
    import usart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] din,
    output logic              cmd_wr,
    output logic              cfg_ready,
    output mode_t             mode_q,
    output logic [BYTE_W-1:0] sync1_q,
    output logic [BYTE_W-1:0] sync2_q
);

    cfg_state_e state_q, state_d;
    mode_t      din_mode;

    assign din_mode  = mode_t'(din);
    assign cmd_wr    = ctl_wr && (state_q == ST_CMD);
    assign cfg_ready = (state_q == ST_CMD);

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique case (state_q)
                ST_MODE:  state_d = is_sync(din_mode) ? ST_SYNC1 : ST_CMD;
                ST_SYNC1: state_d = mode_q.hi[1] ? ST_CMD : ST_SYNC2;
                ST_SYNC2: state_d = ST_CMD;
                ST_CMD:   state_d = din_mode.hi[0] ? ST_MODE : ST_CMD;  // irst = bit 6
                default:  state_d = ST_MODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_MODE;
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            state_q <= state_d;
            if (ctl_wr && state_q == ST_MODE)  mode_q  <= din_mode;
            if (ctl_wr && state_q == ST_SYNC1) sync1_q <= din;
            if (ctl_wr && state_q == ST_SYNC2) sync2_q <= din;
        end
    end

endmodule

// File: rtl/usart_regif_cmd.sv
module usart_regif_cmd
    import usart_regif_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  cmd_t cmd_in,
    output logic err_clr,
    output logic tx_en,
    output logic rx_en,
    output logic send_brk,
    output logic hunt,
    output logic dtr_req,
    output logic rts_req
);

    logic clear_all;

    assign clear_all = cmd_wr && cmd_in.irst;
    assign err_clr   = cmd_wr && (cmd_in.eclr || cmd_in.irst);

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            send_brk <= 1'b0;
            hunt     <= 1'b0;
            dtr_req  <= 1'b0;
            rts_req  <= 1'b0;
        end else if (cmd_wr) begin
            tx_en    <= cmd_in.txe;
            rx_en    <= cmd_in.rxe;
            send_brk <= cmd_in.brk;
            hunt     <= cmd_in.hunt;
            dtr_req  <= cmd_in.dtr;
            rts_req  <= cmd_in.rts;
        end
    end

endmodule

// File: rtl/usart_regif_stat.sv
module usart_regif_stat
    import usart_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             err_clr,
    input  logic [N_ERR-1:0] err_set,   // {framing, overrun, parity}
    input  logic             hold_empty,
    input  logic             rx_avail,
    input  logic             shift_empty,
    input  logic             sync_flag,
    input  logic             dsr_n,
    output status_t          status
);

    logic [N_ERR-1:0] err_q;

    for (genvar i = 0; i < N_ERR; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst)
                err_q[i] <= 1'b0;
            else
                err_q[i] <= (err_q[i] && !err_clr) || err_set[i];
        end
    end

    always_comb begin
        status         = '0;
        status.txrdy   = hold_empty;
        status.rxrdy   = rx_avail;
        status.txempty = shift_empty;
        status.pe      = err_q[0];
        status.oe      = err_q[1];
        status.fe      = err_q[2];
        status.syn     = sync_flag;
        status.dsr     = !dsr_n;
    end

endmodule

// File: rtl/usart_regif.sv
module usart_regif
    import usart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cd_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_take,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              hold_empty,
    input  logic              shift_empty,
    input  logic              rx_avail,
    input  logic              par_set,
    input  logic              ovr_set,
    input  logic              frm_set,
    input  logic              sync_flag,
    input  logic              dsr_n,
    input  logic              cts_n,
    output logic              txrdy_pin,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              tx_en,
    output logic              rx_en,
    output logic              send_brk,
    output logic              hunt,
    output logic              cfg_ready,
    output logic [SEL_W-1:0]  baud_sel,
    output logic [SEL_W-1:0]  char_len,
    output logic              par_en,
    output logic              par_even,
    output logic [SEL_W-1:0]  stop_sel,
    output logic              ext_sync,
    output logic              single_sync,
    output logic [BYTE_W-1:0] sync1,
    output logic [BYTE_W-1:0] sync2
);

    logic    sel, ctl_wr, cmd_wr, err_clr, dtr_req, rts_req, sync_op;
    mode_t   mode_q;
    status_t status;

    assign sel     = !cs_n;
    assign ctl_wr  = sel && cd_sel && wr_stb;
    assign tx_load = sel && !cd_sel && wr_stb;
    assign rx_take = sel && !cd_sel && rd_stb;
    assign tx_byte = din;

    usart_regif_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .din       (din),
        .cmd_wr    (cmd_wr),
        .cfg_ready (cfg_ready),
        .mode_q    (mode_q),
        .sync1_q   (sync1),
        .sync2_q   (sync2)
    );

    usart_regif_cmd u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_in   (cmd_t'(din)),
        .err_clr  (err_clr),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .send_brk (send_brk),
        .hunt     (hunt),
        .dtr_req  (dtr_req),
        .rts_req  (rts_req)
    );

    usart_regif_stat u_stat (
        .clk         (clk),
        .rst         (rst),
        .err_clr     (err_clr),
        .err_set     ({frm_set, ovr_set, par_set}),
        .hold_empty  (hold_empty),
        .rx_avail    (rx_avail),
        .shift_empty (shift_empty),
        .sync_flag   (sync_flag),
        .dsr_n       (dsr_n),
        .status      (status)
    );

    // configuration field decode
    assign sync_op     = is_sync(mode_q);
    assign baud_sel    = mode_q.baud;
    assign char_len    = mode_q.char_len;
    assign par_en      = mode_q.par_en;
    assign par_even    = mode_q.par_even;
    assign stop_sel    = sync_op ? '0 : mode_q.hi;
    assign ext_sync    = sync_op && mode_q.hi[0];
    assign single_sync = sync_op && mode_q.hi[1];

    assign dtr_n     = !dtr_req;
    assign rts_n     = !rts_req;
    assign txrdy_pin = hold_empty && !cts_n && tx_en;

    always_comb begin
        if (sel && rd_stb)
            dout = cd_sel ? BYTE_W'(status) : rx_byte;
        else
            dout = '0;
    end

endmodule

// File: rtl/usart_regif_chk.sv
module usart_regif_chk
    import usart_regif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              cd_sel,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [BYTE_W-1:0] din,
    input logic [BYTE_W-1:0] dout,
    input logic              tx_load,
    input logic              rx_take,
    input logic              par_set,
    input logic              ovr_set,
    input logic              frm_set,
    input logic              cts_n,
    input logic              txrdy_pin,
    input logic              dtr_n,
    input logic              rts_n,
    input logic              cfg_ready
);

    logic ctl, stat_rd, no_set;
    assign ctl     = !cs_n && cd_sel && wr_stb;
    assign stat_rd = !cs_n && cd_sel && rd_stb;
    assign no_set  = !par_set && !ovr_set && !frm_set;

    a_r4_ready_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ready) |-> $past(ctl));

    a_r5_no_cmd_before_ready: assert property (@(posedge clk) disable iff (rst)
        !cfg_ready |=> ($stable(dtr_n) && $stable(rts_n)));

    a_r6_modem_follow: assert property (@(posedge clk) disable iff (rst)
        (ctl && cfg_ready && !din[6]) |=> (dtr_n == !$past(din[1]) && rts_n == !$past(din[5])));

    a_r7_err_cleared: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl && cfg_ready && din[4] && no_set) && stat_rd) |-> (dout[5:3] == 3'b000));

    a_r8_back_to_mode: assert property (@(posedge clk) disable iff (rst)
        (ctl && cfg_ready && din[6]) |=> (!cfg_ready && dtr_n && rts_n));

    a_r10_cts_gates_pin: assert property (@(posedge clk) disable iff (rst)
        cts_n |-> !txrdy_pin);

    a_r12_deselected_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dout == '0 && !tx_load && !rx_take));

endmodule

bind usart_regif usart_regif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .cd_sel    (cd_sel),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .din       (din),
    .dout      (dout),
    .tx_load   (tx_load),
    .rx_take   (rx_take),
    .par_set   (par_set),
    .ovr_set   (ovr_set),
    .frm_set   (frm_set),
    .cts_n     (cts_n),
    .txrdy_pin (txrdy_pin),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .cfg_ready (cfg_ready)
);

// File: tb/usart_regif_tb.sv
`timescale 1ns/1ps
module usart_regif_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, cd_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] din = 8'h00, rx_byte = 8'h00;
    logic hold_empty = 1'b1, shift_empty = 1'b1, rx_avail = 1'b0;
    logic par_set = 1'b0, ovr_set = 1'b0, frm_set = 1'b0;
    logic sync_flag = 1'b0, dsr_n = 1'b1, cts_n = 1'b1;

    logic [7:0] dout, tx_byte, sync1, sync2;
    logic tx_load, rx_take, txrdy_pin, dtr_n, rts_n, tx_en, rx_en, send_brk, hunt;
    logic cfg_ready, par_en, par_even, ext_sync, single_sync;
    logic [1:0] baud_sel, char_len, stop_sel;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    usart_regif u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cd_sel(cd_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .din(din), .dout(dout), .tx_load(tx_load),
        .tx_byte(tx_byte), .rx_take(rx_take), .rx_byte(rx_byte),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .rx_avail(rx_avail),
        .par_set(par_set), .ovr_set(ovr_set), .frm_set(frm_set),
        .sync_flag(sync_flag), .dsr_n(dsr_n), .cts_n(cts_n),
        .txrdy_pin(txrdy_pin), .dtr_n(dtr_n), .rts_n(rts_n), .tx_en(tx_en),
        .rx_en(rx_en), .send_brk(send_brk), .hunt(hunt), .cfg_ready(cfg_ready),
        .baud_sel(baud_sel), .char_len(char_len), .par_en(par_en),
        .par_even(par_even), .stop_sel(stop_sel), .ext_sync(ext_sync),
        .single_sync(single_sync), .sync1(sync1), .sync2(sync2)
    );

    // ---------------- behavioural reference model ----------------
    int   phase = 0;             // 0 await config, 1 first sync, 2 second sync, 3 commands
    bit [7:0] m_cfg = 0, m_s1 = 0, m_s2 = 0, m_cmd = 0;
    bit   m_pe = 0, m_oe = 0, m_fe = 0;

    always @(posedge clk) begin
        bit ctl, clr;
        ctl = !cs_n && cd_sel && wr_stb;
        if (rst) begin
            phase = 0; m_cfg = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0;
            m_pe = 0; m_oe = 0; m_fe = 0;
        end else begin
            clr  = ctl && phase == 3 && (din[4] || din[6]);
            m_pe = (m_pe && !clr) || par_set;
            m_oe = (m_oe && !clr) || ovr_set;
            m_fe = (m_fe && !clr) || frm_set;
            if (ctl) begin
                if (phase == 0) begin
                    m_cfg = din;
                    phase = (din[1:0] == 2'b00) ? 1 : 3;
                end else if (phase == 1) begin
                    m_s1  = din;
                    phase = m_cfg[7] ? 3 : 2;
                end else if (phase == 2) begin
                    m_s2  = din;
                    phase = 3;
                end else if (din[6]) begin
                    phase = 0;
                    m_cmd = 0;
                end else begin
                    m_cmd = din;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_status();
        return {!dsr_n, sync_flag, m_fe, m_oe, m_pe, shift_empty, rx_avail, hold_empty};
    endfunction

    // compare every output on every falling edge (inputs change 1 ns later)
    always @(negedge clk) begin
        bit sync_op;
        bit [7:0] ed;
        sync_op = (m_cfg[1:0] == 2'b00);
        if (!cs_n && rd_stb) ed = cd_sel ? exp_status() : rx_byte;
        else ed = 8'h00;
        chk("R2 cfg_ready", cfg_ready, phase == 3);
        chk("R2 fields", {baud_sel, char_len, par_en, par_even}, {m_cfg[1:0], m_cfg[3:2], m_cfg[4], m_cfg[5]});
        chk("R3 stop_sel", stop_sel, sync_op ? 2'b00 : m_cfg[7:6]);
        chk("R4 sync opts", {ext_sync, single_sync}, {sync_op && m_cfg[6], sync_op && m_cfg[7]});
        chk("R4 sync regs", {sync1, sync2}, {m_s1, m_s2});
        chk("R6 cmd bits", {tx_en, rx_en, send_brk, hunt}, {m_cmd[0], m_cmd[2], m_cmd[3], m_cmd[7]});
        chk("R6 modem", {dtr_n, rts_n}, {!m_cmd[1], !m_cmd[5]});
        chk("R9 dout", dout, ed);
        chk("R10 txrdy_pin", txrdy_pin, hold_empty && !cts_n && m_cmd[0]);
        chk("R11 strobes", {tx_load, rx_take}, {!cs_n && !cd_sel && wr_stb, !cs_n && !cd_sel && rd_stb});
        if (tx_load) chk("R11 tx_byte", tx_byte, din);
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus(input bit ncs, input bit cd, input bit rd, input bit wr, input bit [7:0] d);
        @(negedge clk); #1;
        cs_n = ncs; cd_sel = cd; rd_stb = rd; wr_stb = wr; din = d;
    endtask

    task automatic idle();
        bus(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic ctl_write(input bit [7:0] d);
        bus(1'b0, 1'b1, 1'b0, 1'b1, d);
        idle();
    endtask

    task automatic status_read_check(input string tag, input bit [7:0] exp);
        bus(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
        #1 chk(tag, dout, exp);
        idle();
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 chk("R1 reset outputs", {cfg_ready, tx_en, rx_en, send_brk, hunt, dtr_n, rts_n}, 7'b0000011);
        @(negedge clk); #1 rst = 0;
        idle();

        // R2/R3: async x16, 8 bits, even parity enabled, two stop bits
        ctl_write(8'hFE);
        #1 chk("R2 ready after async config", cfg_ready, 1'b1);
        chk("R3 stop two", stop_sel, 2'b11);

        // R6: tx, dtr, rx, rts
        ctl_write(8'h27);
        #1 chk("R6 dtr/rts low", {dtr_n, rts_n}, 2'b00);
        // R10 gating
        bus(1'b1, 1'b0, 1'b0, 1'b0, 8'h00); cts_n = 0;
        #1 chk("R10 pin ready", txrdy_pin, 1'b1);
        hold_empty = 0;
        #1 chk("R10 pin low when full", txrdy_pin, 1'b0);
        hold_empty = 1; cts_n = 1;
        #1 chk("R10 pin low with cts high", txrdy_pin, 1'b0);
        status_read_check("R9 txrdy bit ignores cts", 8'h05);

        // R7 flags and clear
        bus(1'b1, 1'b0, 1'b0, 1'b0, 8'h00); par_set = 1; frm_set = 1;
        bus(1'b1, 1'b0, 1'b0, 1'b0, 8'h00); par_set = 0; frm_set = 0;
        dsr_n = 0; sync_flag = 1; rx_avail = 1;
        status_read_check("R9 status layout", 8'hEF);
        ctl_write(8'h37);
        status_read_check("R7 flags cleared", 8'hC7);
        // clear with simultaneous set: set wins
        bus(1'b0, 1'b1, 1'b0, 1'b1, 8'h17); ovr_set = 1;
        idle(); ovr_set = 0;
        status_read_check("R7 set beats clear", 8'hD7);

        // R11 data path
        rx_byte = 8'h5A;
        bus(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        #1 chk("R11 data read", {rx_take, dout}, {1'b1, 8'h5A});
        bus(1'b0, 1'b0, 1'b0, 1'b1, 8'hC3);
        #1 chk("R11 data write", {tx_load, tx_byte}, {1'b1, 8'hC3});

        // R12 deselected strobes
        bus(1'b1, 1'b1, 1'b1, 1'b1, 8'h40);
        #1 chk("R12 deselected dout", {dout, tx_load, rx_take}, 10'h000);
        idle();
        #1 chk("R12 no internal reset", cfg_ready, 1'b1);

        // R8 internal reset
        ctl_write(8'h6F);
        #1 chk("R8 back to config wait", {cfg_ready, tx_en, dtr_n, rts_n}, 4'b0011);
        chk("R8 config kept", baud_sel, 2'b10);
        status_read_check("R8 flags cleared", 8'hC7);

        // R4/R5 synchronous, two sync chars
        ctl_write(8'h1C);
        #1 chk("R4 not ready after sync config", cfg_ready, 1'b0);
        ctl_write(8'hFF);
        #1 chk("R5 sync write leaves modem", {dtr_n, rts_n, tx_en}, 3'b110);
        chk("R4 waiting second sync", cfg_ready, 1'b0);
        ctl_write(8'h16);
        #1 chk("R4 two syncs stored", {cfg_ready, sync1, sync2}, {1'b1, 8'hFF, 8'h16});
        ctl_write(8'h85);
        #1 chk("R6 hunt held", {hunt, tx_en, rx_en}, 3'b111);
        ctl_write(8'h40);

        // R4 single sync, external detection
        ctl_write(8'hCC);
        #1 chk("R4 single/ext", {single_sync, ext_sync, stop_sel}, 4'b1100);
        ctl_write(8'h3C);
        #1 chk("R4 one sync enough", {cfg_ready, sync1}, {1'b1, 8'h3C});

        // async x1 with invalid stop code
        ctl_write(8'h40);
        ctl_write(8'h01);
        #1 chk("R3 stop code 00", {cfg_ready, stop_sel}, 3'b100);

        // random traffic, model compares every clock
        for (int i = 0; i < 600; i++) begin
            bit [7:0] d;
            d = 8'($urandom);
            if ((d[6]) && ($urandom % 4 != 0)) d[6] = 1'b0;
            bus(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom), 1'($urandom), d);
            par_set = 1'($urandom % 8 == 0); ovr_set = 1'($urandom % 8 == 0);
            frm_set = 1'($urandom % 8 == 0); cts_n = 1'($urandom);
            hold_empty = 1'($urandom); rx_avail = 1'($urandom); dsr_n = 1'($urandom);
            rx_byte = 8'($urandom);
        end
        idle();
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule